// File: doc/BRIEF.md
# Crosspoint Configuration Register Bank

This block keeps the routing state of a 68-output crosspoint and applies it. A host reaches it through a narrow parallel port. The port has an active-low chip select, a write strobe, a read/write select, a 7-bit channel number, a bank-select line and a 7-bit data field. Behind the port sit two banks of 68 registers.

- The routing bank (`bank_sel` = 0) holds, for each output, the number of the input that feeds it.
- The gating bank (`bank_sel` = 1) holds a per-output word. Bit 0 of that word switches the output on.

Each of the 68 one-bit output lanes is driven by a multiplexer that its routing register steers.

Everything runs on one system clock. A write is taken on the first cycle the sampled write strobe is seen high after being low, with chip select low and the port in write mode. Channel code 127 writes the same value into every register of the selected bank in one access, which speeds up bring-up after reset. Read-back is registered. The data pins go to high impedance when the device is not selected for a read, so several devices can share one host bus.

Top module: `xpt_cfg_bank`

## Requirements
- R1: After reset every register of both banks reads 0, `data_oe` is 0 and every output lane is 0.
- R2: A write (chip select low, `rd_nwr` = 0, rising edge of `wr_strobe`) to channel 0..67 loads `data_in` into that channel's register of the bank chosen by `bank_sel` (0 = routing, 1 = gating), and no other register changes.
- R3: While `cs_n` is high, strobe edges change no register. `data_oe` is 0 on the cycle after any cycle with `cs_n` high.
- R4: A write to channel code 127 loads `data_in` into all 68 registers of the selected bank and leaves the other bank unchanged.
- R5: Writes to channel codes 68..126 change no register, and reads from those codes return 0.
- R6: With `cs_n` low and `rd_nwr` = 1, `data_q` and `data_pad` show the addressed register of the selected bank one clock later, with `data_oe` = 1.
- R7: A strobe held high for several cycles performs exactly one write, using the values present on its first high cycle.
- R8: Output lane o equals input lane n when routing register o holds n (n < 68) and gating register o has bit 0 set.
- R9: A routing value of 68 or above drives its output lane low.
- R10: When bit 0 of gating register o is clear, output lane o is low whatever its routing value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| wr_strobe | input | 1 | Write strobe; its rising edge commits a write |
| rd_nwr | input | 1 | 1 = read access, 0 = write access |
| bank_sel | input | 1 | 0 = routing bank, 1 = gating bank |
| chan | input | 7 | Channel number; 127 = broadcast write |
| data_in | input | 7 | Write data |
| data_q | output | 7 | Registered read data (0 when not reading) |
| data_oe | output | 1 | High while the read data is driven |
| data_pad | output | 7 | Read data, high impedance while `data_oe` is 0 |
| in_lanes | input | 68 | Crosspoint input lanes |
| out_lanes | output | 68 | Crosspoint output lanes |

## Verification
The hardest state to reach from the ports is a routing register that holds a value above 67 while its output is enabled. Only a full-width write can produce it, and after reset it never occurs. The bench writes 70 into one routing register, enables that output and drives all input lanes high, so the lane must still read 0. A strobe held high across several cycles while the data changes is the other awkward case, because only the first high cycle may write.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
   typedef enum logic {
      BANK_ROUTE = 1'b0,
      BANK_GATE  = 1'b1
   } bank_e;
endpackage

// File: rtl/xpt_port_if.sv
module xpt_port_if
   import xpt_cfg_pkg::*;
#(
   parameter int NUM_CH = 68,
   parameter int CH_W   = 7,
   parameter int DATA_W = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 wr_strobe,
   input  logic                 rd_nwr,
   input  logic                 bank_sel,
   input  logic [CH_W-1:0]      chan,
   input  logic [DATA_W-1:0]    rd_route_val,
   input  logic [DATA_W-1:0]    rd_gate_val,
   output logic [NUM_CH-1:0]    we_route,
   output logic [NUM_CH-1:0]    we_gate,
   output logic [DATA_W-1:0]    data_q,
   output logic                 data_oe
);
   localparam logic [CH_W-1:0] BCAST = {CH_W{1'b1}};

   logic stb_q;
   logic wr_fire;
   logic rd_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q <= 1'b0;
      else        stb_q <= wr_strobe;
   end

   assign wr_fire = wr_strobe & ~stb_q & ~cs_n & ~rd_nwr;
   assign rd_act  = ~cs_n & rd_nwr;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
      logic hit;
      assign hit         = wr_fire & ((chan == CH_W'(i)) | (chan == BCAST));
      assign we_route[i] = hit & (bank_e'(bank_sel) == BANK_ROUTE);
      assign we_gate[i]  = hit & (bank_e'(bank_sel) == BANK_GATE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         data_oe <= 1'b0;
      end else begin
         data_oe <= rd_act;
         if (!rd_act)
            data_q <= '0;
         else if (bank_e'(bank_sel) == BANK_GATE)
            data_q <= rd_gate_val;
         else
            data_q <= rd_route_val;
      end
   end

   assert_oe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !data_oe);
   assert_oe_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && rd_nwr) |=> data_oe);
   assert_edge_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |=> !wr_fire);
   assert_no_wr_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (we_route == '0 && we_gate == '0));
endmodule

// File: rtl/xpt_reg_bank.sv
module xpt_reg_bank #(
   parameter int NUM_CH = 68,
   parameter int CH_W   = 7,
   parameter int DATA_W = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CH-1:0]          we,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [CH_W-1:0]            rd_chan,
   output logic [NUM_CH*DATA_W-1:0]   q_flat,
   output logic [DATA_W-1:0]          rd_val
);
   logic [DATA_W-1:0] regs [NUM_CH];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     regs[i] <= '0;
         else if (we[i]) regs[i] <= wdata;
      end
      assign q_flat[i*DATA_W +: DATA_W] = regs[i];

      assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
         we[i] |=> (regs[i] == $past(wdata)));
      assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !we[i] |=> $stable(regs[i]));
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (rd_chan == CH_W'(i)) rd_val = regs[i];
   end
endmodule

// File: rtl/xpt_out_mux.sv
module xpt_out_mux #(
   parameter int NUM_CH = 68,
   parameter int DATA_W = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CH-1:0]          in_lanes,
   input  logic [NUM_CH*DATA_W-1:0]   route_flat,
   input  logic [NUM_CH*DATA_W-1:0]   gate_flat,
   output logic [NUM_CH-1:0]          out_lanes
);
   for (genvar o = 0; o < NUM_CH; o++) begin : g_out
      logic [DATA_W-1:0] sel;
      logic              en;
      logic              lane;
      assign sel = route_flat[o*DATA_W +: DATA_W];
      assign en  = gate_flat[o*DATA_W];
      always_comb begin
         lane = 1'b0;
         if (int'(sel) < NUM_CH) lane = in_lanes[sel];
      end
      assign out_lanes[o] = en & lane;

      assert_gate_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !gate_flat[o*DATA_W] |-> !out_lanes[o]);
      assert_range_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(route_flat[o*DATA_W +: DATA_W]) >= NUM_CH) |-> !out_lanes[o]);
   end
endmodule

// File: rtl/xpt_cfg_bank.sv
module xpt_cfg_bank
   import xpt_cfg_pkg::*;
#(
   parameter int NUM_CH       = 68,
   parameter int CH_W         = 7,
   parameter int DATA_W       = 7,
   parameter bit TRISTATE_PAD = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 wr_strobe,
   input  logic                 rd_nwr,
   input  logic                 bank_sel,
   input  logic [CH_W-1:0]      chan,
   input  logic [DATA_W-1:0]    data_in,
   output logic [DATA_W-1:0]    data_q,
   output logic                 data_oe,
   output logic [DATA_W-1:0]    data_pad,
   input  logic [NUM_CH-1:0]    in_lanes,
   output logic [NUM_CH-1:0]    out_lanes
);
   localparam int BANK_BITS = NUM_CH * DATA_W;

   if (NUM_CH >= (1 << CH_W) - 1) begin : g_chk_ch
      $error("NUM_CH must leave the all-ones channel code free");
   end
   if ($clog2(NUM_CH) > DATA_W) begin : g_chk_dw
      $error("DATA_W too narrow to name every input");
   end

   logic [NUM_CH-1:0]    we_route, we_gate;
   logic [BANK_BITS-1:0] route_flat, gate_flat;
   logic [DATA_W-1:0]    rd_route_val, rd_gate_val;

   xpt_port_if #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W)) u_port (
      .clk, .rst_n, .cs_n, .wr_strobe, .rd_nwr, .bank_sel, .chan,
      .rd_route_val, .rd_gate_val, .we_route, .we_gate, .data_q, .data_oe
   );

   xpt_reg_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W)) u_route (
      .clk, .rst_n, .we(we_route), .wdata(data_in), .rd_chan(chan),
      .q_flat(route_flat), .rd_val(rd_route_val)
   );

   xpt_reg_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W)) u_gate (
      .clk, .rst_n, .we(we_gate), .wdata(data_in), .rd_chan(chan),
      .q_flat(gate_flat), .rd_val(rd_gate_val)
   );

   xpt_out_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_mux (
      .clk, .rst_n, .in_lanes, .route_flat, .gate_flat, .out_lanes
   );

   if (TRISTATE_PAD) begin : g_pad_z
      assign data_pad = data_oe ? data_q : 'z;
   end else begin : g_pad_0
      assign data_pad = data_oe ? data_q : '0;
   end

   assert_bcast_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !rd_nwr && chan == {CH_W{1'b1}} && (we_route != '0))
         |-> (we_route == {NUM_CH{1'b1}}));
endmodule

// File: tb/xpt_cfg_bank_tb.sv
module xpt_cfg_bank_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N = 68;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, wr_strobe = 1'b0, rd_nwr = 1'b1, bank_sel = 1'b0;
   logic [6:0] chan = '0, data_in = '0;
   logic [6:0] data_q, data_pad;
   logic data_oe;
   logic [N-1:0] in_lanes = '0, out_lanes;

   int checks = 0, failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xpt_cfg_bank u_dut (
      .clk, .rst_n, .cs_n, .wr_strobe, .rd_nwr, .bank_sel, .chan, .data_in,
      .data_q, .data_oe, .data_pad, .in_lanes, .out_lanes
   );

   // vector: {read, bank, chan[6:0], data[6:0]}; bank 0 = routing, 1 = gating
   localparam int NV = 14;
   localparam logic [15:0] VEC [NV] = '{
      {1'b0, 1'b0, 7'd0,   7'd5},   // R2 write routing 0
      {1'b0, 1'b0, 7'd67,  7'd66},  // R2 last channel
      {1'b0, 1'b1, 7'd12,  7'h55},  // R2 gating 12
      {1'b0, 1'b0, 7'd68,  7'd9},   // R5 ignored
      {1'b1, 1'b0, 7'd0,   7'd5},
      {1'b1, 1'b0, 7'd67,  7'd66},
      {1'b1, 1'b1, 7'd12,  7'h55},
      {1'b1, 1'b0, 7'd12,  7'd0},   // R2 other bank untouched
      {1'b1, 1'b1, 7'd0,   7'd0},
      {1'b1, 1'b0, 7'd68,  7'd0},   // R5 read zero
      {1'b1, 1'b0, 7'd126, 7'd0},   // R5
      {1'b0, 1'b1, 7'd126, 7'd3},   // R5 ignored
      {1'b1, 1'b1, 7'd126, 7'd0},
      {1'b1, 1'b0, 7'd1,   7'd0}
   };

   task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_lanes(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic b, input logic [6:0] c, input logic [6:0] d);
      @(negedge clk);
      cs_n = 1'b0; rd_nwr = 1'b0; bank_sel = b; chan = c; data_in = d; wr_strobe = 1'b1;
      @(negedge clk);
      wr_strobe = 1'b0;
      @(negedge clk);
      cs_n = 1'b1; rd_nwr = 1'b1;
   endtask

   task automatic rd(input logic b, input logic [6:0] c, output logic [6:0] v);
      @(negedge clk);
      cs_n = 1'b0; rd_nwr = 1'b1; bank_sel = b; chan = c;
      @(negedge clk);
      v = data_q;
      chk("R6 oe during read", {6'd0, data_oe}, 7'd1);
      cs_n = 1'b1;
   endtask

   initial begin
      repeat (CLK_PERIOD * 20000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [6:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 oe after reset", {6'd0, data_oe}, 7'd0);
      in_lanes = '1;
      #1 chk_lanes("R1 lanes after reset", out_lanes, '0);
      rd(1'b0, 7'd33, v); chk("R1 routing reg zero", v, 7'd0);
      rd(1'b1, 7'd50, v); chk("R1 gating reg zero", v, 7'd0);

      // vector walk: R2 R5 R6
      for (int k = 0; k < NV; k++) begin
         if (VEC[k][15]) begin
            rd(VEC[k][14], VEC[k][13:7], v);
            chk($sformatf("R2/R5/R6 vec %0d", k), v, VEC[k][6:0]);
         end else begin
            wr(VEC[k][14], VEC[k][13:7], VEC[k][6:0]);
         end
      end

      // R3 strobe while deselected
      @(negedge clk);
      cs_n = 1'b1; rd_nwr = 1'b0; bank_sel = 1'b0; chan = 7'd0; data_in = 7'd9; wr_strobe = 1'b1;
      @(negedge clk); wr_strobe = 1'b0; rd_nwr = 1'b1;
      rd(1'b0, 7'd0, v); chk("R3 deselected write ignored", v, 7'd5);

      // R3 oe drops one cycle after cs_n rises
      @(negedge clk); cs_n = 1'b0; rd_nwr = 1'b1; chan = 7'd0;
      @(negedge clk); chk("R6 oe on", {6'd0, data_oe}, 7'd1);
      chk("R6 pad value", data_pad, 7'd5);
      cs_n = 1'b1;
      #1 chk("R3 oe held until edge", {6'd0, data_oe}, 7'd1);
      @(negedge clk); chk("R3 oe off", {6'd0, data_oe}, 7'd0);
      chk("R3 data_q cleared", data_q, 7'd0);

      // R7 held strobe writes once with first values
      @(negedge clk);
      cs_n = 1'b0; rd_nwr = 1'b0; bank_sel = 1'b1; chan = 7'd20; data_in = 7'd7; wr_strobe = 1'b1;
      @(negedge clk); data_in = 7'd9;
      @(negedge clk); data_in = 7'd11;
      @(negedge clk); wr_strobe = 1'b0; cs_n = 1'b1; rd_nwr = 1'b1;
      rd(1'b1, 7'd20, v); chk("R7 held strobe single write", v, 7'd7);

      // R8 routing
      wr(1'b1, 7'd5, 7'd1);
      wr(1'b0, 7'd5, 7'd10);
      in_lanes = '0; in_lanes[10] = 1'b1;
      #1 chk({6'd0, out_lanes[5]} == 7'd1 ? "R8 lane follows input" : "R8 lane follows input", {6'd0, out_lanes[5]}, 7'd1);
      in_lanes = '1; in_lanes[10] = 1'b0;
      #1 chk("R8 lane follows low input", {6'd0, out_lanes[5]}, 7'd0);
      // R9 out of range routing
      wr(1'b0, 7'd5, 7'd70);
      in_lanes = '1;
      #1 chk("R9 range forces low", {6'd0, out_lanes[5]}, 7'd0);
      // R10 gating clear
      wr(1'b0, 7'd5, 7'd10);
      #1 chk("R8 enabled lane high", {6'd0, out_lanes[5]}, 7'd1);
      wr(1'b1, 7'd5, 7'd0);
      #1 chk("R10 gate clear forces low", {6'd0, out_lanes[5]}, 7'd0);

      // R4 broadcast
      wr(1'b0, 7'd127, 7'd3);
      rd(1'b0, 7'd0, v);  chk("R4 routing bcast ch0", v, 7'd3);
      rd(1'b0, 7'd67, v); chk("R4 routing bcast ch67", v, 7'd3);
      rd(1'b1, 7'd12, v); chk("R4 other bank kept", v, 7'h55);
      wr(1'b1, 7'd127, 7'd1);
      in_lanes = '0; in_lanes[3] = 1'b1;
      #1 chk_lanes("R4 R8 all lanes from input 3", out_lanes, '1);
      in_lanes = '0;
      #1 chk_lanes("R8 all lanes low", out_lanes, '0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule